// File: doc/BRIEF.md
# Ping-Pong DMA Buffer with Diagnostic Back Door

This block sits between an image-data producer and a DMA engine that moves data out to external memory. It holds two buffers of 64 entries, each 16 bits wide. The producer writes into one buffer while the DMA side reads the other. The two roles change over only when the producer's buffer is completely filled and the DMA side has emptied the other buffer. Each buffer has a ready flag. The flag rises when the buffer has been filled and falls once the DMA side has taken all 64 of its entries.

A processor running on its own clock can read or write single entries through a secondary port. This port is intended for diagnostics only. Each access is passed to the buffer clock domain by a toggle handshake with two-flop synchronizers in both directions, and the processor is held with `cpu_ready_o` low until the acknowledge has come back. Only 16-bit accesses to even byte addresses are accepted. Any other access completes with an error flag and has no effect. In the processor byte address, the most significant bit selects the buffer and the bits below it, down to bit 1, select the entry.

Top module: `pingpong_dma_buf`

## Requirements
- R1: While reset is held and after it is released, `wr_ready_o`=1, `rd_valid_o`=0, `full_o`=2'b00, `fill_sel_o`=0, `cpu_ready_o`=0 and `cpu_err_o`=0.
- R2: Each accepted producer write (`wr_valid_i` && `wr_ready_o`) stores one word at the next entry of buffer `fill_sel_o`, starting at entry 0. The 64th write sets `full_o[fill_sel_o]`, and `wr_ready_o` is low while that flag is set.
- R3: The roles swap (`fill_sel_o` inverts) only on the clock edge after the fill buffer is full while the other buffer is not full. After a swap, both the write pointer and the read pointer start again at entry 0.
- R4: `rd_valid_o` equals the ready flag of the drain buffer (the one that is not `fill_sel_o`). `rd_data_o` presents the entries in order from 0 to 63, and each `rd_ready_i` handshake advances to the next entry. The 64th read clears the ready flag on the same edge.
- R5: When both buffers are full, the producer is stalled and no swap takes place. The swap happens on the edge after the drain buffer's flag clears.
- R6: On the diagnostic port, `cpu_addr_i[7]` selects the buffer (0 = buffer 0) and `cpu_addr_i[6:1]` selects the entry. A write stores `cpu_wdata_i`, and a read returns the stored entry on `cpu_rdata_o`.
- R7: The only legal access uses `cpu_size_i`=2'b01 (16 bits) with `cpu_addr_i[0]`=0. Size codes 2'b00 (byte) and 2'b10 (32 bits), and odd addresses, complete one cycle after the request with `cpu_err_o`=1, `cpu_rdata_o`=0, and no change to any buffer.
- R8: A legal diagnostic access completes only after the request toggle has been synchronized into the buffer domain and the acknowledge toggle has been synchronized back. `cpu_ready_o` therefore rises no earlier than the 4th processor clock after the request is taken.
- R9: A diagnostic write into the buffer currently being drained takes effect and is seen by the DMA reads. It leaves `full_o`, `fill_sel_o` and `rd_valid_o` unchanged.
- R10: `cpu_ready_o` is high for exactly one processor cycle per access. `cpu_rdata_o` and `cpu_err_o` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Buffer-domain clock (producer and DMA) |
| cpu_clk_i | input | 1 | Processor-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid_i | input | 1 | Producer word valid |
| wr_data_i | input | 16 | Producer word |
| wr_ready_o | output | 1 | Fill buffer can accept a word |
| rd_valid_o | output | 1 | Drain buffer holds data |
| rd_data_o | output | 16 | Current drain entry |
| rd_ready_i | input | 1 | DMA takes the current entry |
| full_o | output | 2 | Ready flag for each buffer |
| fill_sel_o | output | 1 | Buffer the producer is filling |
| cpu_req_i | input | 1 | Diagnostic request, held until `cpu_ready_o` |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 8 | Byte address; bit 7 selects the buffer |
| cpu_size_i | input | 2 | Access size code (2'b01 = 16 bits) |
| cpu_wdata_i | input | 16 | Write data |
| cpu_rdata_o | output | 16 | Read data |
| cpu_ready_o | output | 1 | One-cycle completion strobe |
| cpu_err_o | output | 1 | Access was illegal and ignored |

## Verification
Producer and DMA results are due one buffer clock after the accepting edge: flags and pointers change on that edge, and a swap lands on the edge after that. The bench therefore drives on falling edges and samples at the next falling edge, or at the one after it when it checks a swap. `rd_data_o` is combinational from the read pointer, so each entry is sampled in the half cycle before it is taken. The latency of a diagnostic access depends on the ratio of the two clocks, so the bench counts processor cycles until `cpu_ready_o` rises. It checks a lower bound for legal accesses and a count of exactly one for illegal ones, then checks one cycle later that the strobe has fallen.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    DBG_IDLE = 2'd0,
    DBG_WAIT = 2'd1,
    DBG_DONE = 2'd2
  } dbg_state_e;

  localparam int unsigned NBUF = 2;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          p_we_i,
  input  logic          p_sel_i,
  input  logic [IW-1:0] p_idx_i,
  input  logic [DW-1:0] p_data_i,
  input  logic          d_we_i,
  input  logic          d_sel_i,
  input  logic [IW-1:0] d_idx_i,
  input  logic [DW-1:0] d_data_i,
  input  logic          r_sel_i,
  input  logic [IW-1:0] r_idx_i,
  output logic [DW-1:0] r_data_o,
  input  logic          q_sel_i,
  input  logic [IW-1:0] q_idx_i,
  output logic [DW-1:0] q_data_o
);
  logic [DW-1:0] r_arr [pp_pkg::NBUF];
  logic [DW-1:0] q_arr [pp_pkg::NBUF];

  for (genvar b = 0; b < pp_pkg::NBUF; b++) begin : g_buf
    logic [DW-1:0] mem [DEPTH];
    // diagnostic port written last: wins on a same-entry collision
    always_ff @(posedge clk_i) begin
      if (p_we_i && p_sel_i == 1'(b)) mem[p_idx_i] <= p_data_i;
      if (d_we_i && d_sel_i == 1'(b)) mem[d_idx_i] <= d_data_i;
    end
    assign r_arr[b] = mem[r_idx_i];
    assign q_arr[b] = mem[q_idx_i];
  end

  assign r_data_o = r_arr[r_sel_i];
  assign q_data_o = q_arr[q_sel_i];
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic          rd_ready_i,
  output logic          wr_ready_o,
  output logic          wr_fire_o,
  output logic          rd_valid_o,
  output logic [1:0]    full_o,
  output logic          fill_sel_o,
  output logic [IW-1:0] wptr_o,
  output logic [IW-1:0] rptr_o
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [1:0]    full_q;
  logic          fill_q;
  logic [IW-1:0] wptr_q, rptr_q;
  logic          drain_sel, rd_fire, swap;

  assign drain_sel  = ~fill_q;
  assign wr_ready_o = ~full_q[fill_q];
  assign wr_fire_o  = wr_valid_i & wr_ready_o;
  assign rd_valid_o = full_q[drain_sel];
  assign rd_fire    = rd_ready_i & rd_valid_o;
  assign swap       = full_q[fill_q] & ~full_q[drain_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      fill_q <= 1'b0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_fire_o) begin
        wptr_q <= wptr_q + IW'(1);
        if (wptr_q == LAST) full_q[fill_q] <= 1'b1;
      end
      if (rd_fire) begin
        rptr_q <= rptr_q + IW'(1);
        if (rptr_q == LAST) full_q[drain_sel] <= 1'b0;
      end
      if (swap) fill_q <= ~fill_q;
    end
  end

  assign full_o     = full_q;
  assign fill_sel_o = fill_q;
  assign wptr_o     = wptr_q;
  assign rptr_o     = rptr_q;

  AST_FILL_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire_o && wptr_q == LAST) |=> full_q[$past(fill_q)]); // R2
  AST_SWAP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q != $past(fill_q)) |-> ($past(full_q) == (2'b01 << $past(fill_q)))); // R3
  AST_SWAP_PTRS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |-> (wptr_q == '0 && rptr_q == '0)); // R3
  AST_DRAIN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && rptr_q == LAST) |=> !full_q[$past(drain_sel)]); // R4
  AST_BOTH_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q == 2'b11) |=> $stable(fill_q)); // R5
endmodule

// File: rtl/pp_dbg_cpu.sv
module pp_dbg_cpu #(
  parameter int unsigned DW  = 16,
  parameter int unsigned CAW = 8
) (
  input  logic           cpu_clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [CAW-1:0] addr_i,
  input  logic [1:0]     size_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           ack_tgl_i,
  input  logic [DW-1:0]  buf_rdata_i,
  output logic           ready_o,
  output logic           err_o,
  output logic [DW-1:0]  rdata_o,
  output logic           req_tgl_o,
  output logic           hold_we_o,
  output logic [CAW-1:0] hold_addr_o,
  output logic [DW-1:0]  hold_wdata_o
);
  import pp_pkg::*;

  dbg_state_e state_q;
  logic       ack_s1, ack_s2;
  logic       legal;

  assign legal = (size_i == SZ_HALF) && !addr_i[0];

  always_ff @(posedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl_i;
      ack_s2 <= ack_s1;
    end
  end

  always_ff @(posedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= DBG_IDLE;
      ready_o      <= 1'b0;
      err_o        <= 1'b0;
      rdata_o      <= '0;
      req_tgl_o    <= 1'b0;
      hold_we_o    <= 1'b0;
      hold_addr_o  <= '0;
      hold_wdata_o <= '0;
    end else begin
      ready_o <= 1'b0;
      err_o   <= 1'b0;
      unique case (state_q)
        DBG_IDLE: if (req_i) begin
          if (legal) begin
            hold_we_o    <= we_i;
            hold_addr_o  <= addr_i;
            hold_wdata_o <= wdata_i;
            req_tgl_o    <= ~req_tgl_o;
            state_q      <= DBG_WAIT;
          end else begin
            ready_o <= 1'b1;
            err_o   <= 1'b1;
            rdata_o <= '0;
            state_q <= DBG_DONE;
          end
        end
        DBG_WAIT: if (ack_s2 == req_tgl_o) begin
          ready_o <= 1'b1;
          rdata_o <= hold_we_o ? '0 : buf_rdata_i;
          state_q <= DBG_DONE;
        end
        // one spare cycle lets the master drop its request
        DBG_DONE: state_q <= DBG_IDLE;
        default:  state_q <= DBG_IDLE;
      endcase
    end
  end

  AST_READY_PULSE: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R10
  AST_LEGAL_AFTER_WAIT: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    (ready_o && !err_o) |-> ($past(state_q) == DBG_WAIT)); // R8
  AST_HOLD_STABLE: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    (state_q == DBG_WAIT) |=> ($stable(hold_addr_o) && $stable(hold_wdata_o))); // R8
endmodule

// File: rtl/pp_dbg_buf.sv
module pp_dbg_buf #(
  parameter int unsigned DW  = 16,
  parameter int unsigned CAW = 8,
  localparam int unsigned IW = CAW - 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_tgl_i,
  input  logic           hold_we_i,
  input  logic [CAW-1:0] hold_addr_i,
  input  logic [DW-1:0]  hold_wdata_i,
  input  logic [DW-1:0]  bank_q_i,
  output logic           ack_tgl_o,
  output logic           d_we_o,
  output logic           d_sel_o,
  output logic [IW-1:0]  d_idx_o,
  output logic [DW-1:0]  d_data_o,
  output logic [DW-1:0]  rdata_o
);
  logic req_s1, req_s2, go;

  assign go       = req_s2 ^ ack_tgl_o;
  assign d_we_o   = go & hold_we_i;
  assign d_sel_o  = hold_addr_i[CAW-1];
  assign d_idx_o  = hold_addr_i[CAW-2:1];
  assign d_data_o = hold_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s1    <= 1'b0;
      req_s2    <= 1'b0;
      ack_tgl_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      req_s1 <= req_tgl_i;
      req_s2 <= req_s1;
      if (go) begin
        ack_tgl_o <= req_s2;
        if (!hold_we_i) rdata_o <= bank_q_i;
      end
    end
  end

  AST_ONE_ACCESS_PER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> !go); // R8
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |=> $stable(rdata_o)); // R6
endmodule

// File: rtl/pingpong_dma_buf.sv
module pingpong_dma_buf #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CAW  = IW + 2
) (
  input  logic           clk_i,
  input  logic           cpu_clk_i,
  input  logic           rst_ni,
  input  logic           wr_valid_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic           wr_ready_o,
  output logic           rd_valid_o,
  output logic [DW-1:0]  rd_data_o,
  input  logic           rd_ready_i,
  output logic [1:0]     full_o,
  output logic           fill_sel_o,
  input  logic           cpu_req_i,
  input  logic           cpu_we_i,
  input  logic [CAW-1:0] cpu_addr_i,
  input  logic [1:0]     cpu_size_i,
  input  logic [DW-1:0]  cpu_wdata_i,
  output logic [DW-1:0]  cpu_rdata_o,
  output logic           cpu_ready_o,
  output logic           cpu_err_o
);
  logic           wr_fire;
  logic [IW-1:0]  wptr, rptr;
  logic           req_tgl, ack_tgl, hold_we;
  logic [CAW-1:0] hold_addr;
  logic [DW-1:0]  hold_wdata, bank_q, dbg_rdata, d_data;
  logic           d_we, d_sel;
  logic [IW-1:0]  d_idx;

  pp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_valid_i, .rd_ready_i, .wr_ready_o,
    .wr_fire_o(wr_fire), .rd_valid_o, .full_o, .fill_sel_o,
    .wptr_o(wptr), .rptr_o(rptr)
  );

  pp_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
    .clk_i,
    .p_we_i(wr_fire), .p_sel_i(fill_sel_o), .p_idx_i(wptr), .p_data_i(wr_data_i),
    .d_we_i(d_we), .d_sel_i(d_sel), .d_idx_i(d_idx), .d_data_i(d_data),
    .r_sel_i(~fill_sel_o), .r_idx_i(rptr), .r_data_o(rd_data_o),
    .q_sel_i(d_sel), .q_idx_i(d_idx), .q_data_o(bank_q)
  );

  pp_dbg_cpu #(.DW(DW), .CAW(CAW)) u_dbg_cpu (
    .cpu_clk_i, .rst_ni, .req_i(cpu_req_i), .we_i(cpu_we_i), .addr_i(cpu_addr_i),
    .size_i(cpu_size_i), .wdata_i(cpu_wdata_i), .ack_tgl_i(ack_tgl),
    .buf_rdata_i(dbg_rdata), .ready_o(cpu_ready_o), .err_o(cpu_err_o),
    .rdata_o(cpu_rdata_o), .req_tgl_o(req_tgl), .hold_we_o(hold_we),
    .hold_addr_o(hold_addr), .hold_wdata_o(hold_wdata)
  );

  pp_dbg_buf #(.DW(DW), .CAW(CAW)) u_dbg_buf (
    .clk_i, .rst_ni, .req_tgl_i(req_tgl), .hold_we_i(hold_we),
    .hold_addr_i(hold_addr), .hold_wdata_i(hold_wdata), .bank_q_i(bank_q),
    .ack_tgl_o(ack_tgl), .d_we_o(d_we), .d_sel_o(d_sel), .d_idx_o(d_idx),
    .d_data_o(d_data), .rdata_o(dbg_rdata)
  );

  AST_DIAG_KEEPS_ROLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we && !wr_fire && !rd_ready_i && !(full_o[fill_sel_o] && !full_o[~fill_sel_o]))
      |=> ($stable(full_o) && $stable(fill_sel_o))); // R9
endmodule

// File: tb/sim_pingpong_dma_buf.sv
`timescale 1ns/1ps
module sim_pingpong_dma_buf;
  logic clk = 1'b0, cpu_clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [15:0] wr_data = '0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic [1:0] cpu_size = 2'b01;
  logic [15:0] cpu_wdata = '0;
  logic wr_ready, rd_valid, fill_sel, cpu_ready, cpu_err;
  logic [15:0] rd_data, cpu_rdata;
  logic [1:0] full;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;           // 125 MHz
  always #5.5 cpu_clk = ~cpu_clk; // processor domain

  pingpong_dma_buf u0 (
    .clk_i(clk), .cpu_clk_i(cpu_clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_ready_i(rd_ready),
    .full_o(full), .fill_sel_o(fill_sel),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_size_i(cpu_size), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .cpu_ready_o(cpu_ready), .cpu_err_o(cpu_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop(input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_ready = 1'b1;
    while (!rd_valid) @(negedge clk);
    chk(tag, 32'(rd_data), 32'(exp));
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic cpu_acc(input logic we, input logic [7:0] a, input logic [1:0] sz,
                         input logic [15:0] wd, output logic [15:0] rd,
                         output logic er, output int n);
    @(negedge cpu_clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    n = 0;
    do begin
      @(negedge cpu_clk);
      n++;
    end while (!cpu_ready && n < 200);
    rd = cpu_rdata;
    er = cpu_err;
    cpu_req = 1'b0;
    @(negedge cpu_clk);
    chk("R10 ready is one cycle", 32'(cpu_ready), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 wr_ready", 32'(wr_ready), 32'd1);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 fill_sel", 32'(fill_sel), 32'd0);
    chk("R1 cpu_ready", 32'(cpu_ready), 32'd0);
    chk("R1 cpu_err", 32'(cpu_err), 32'd0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 64; i++) push(16'h1000 + 16'(i));
    chk("R2 flag after 64 writes", 32'(full), 32'b01);
    chk("R2 producer stalled", 32'(wr_ready), 32'd0);
    @(negedge clk);
    chk("R3 swap fill_sel", 32'(fill_sel), 32'd1);
    chk("R3 producer resumes", 32'(wr_ready), 32'd1);
    chk("R4 rd_valid", 32'(rd_valid), 32'd1);
    for (int i = 0; i < 64; i++) pop(16'h1000 + 16'(i), "R4 drain order");
    chk("R4 flag cleared", 32'(full), 32'd0);
    chk("R4 rd_valid low", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_both_full();
    for (int i = 0; i < 64; i++) push(16'h2000 + 16'(i));
    @(negedge clk);
    chk("R3 second swap", 32'(fill_sel), 32'd0);
    for (int i = 0; i < 64; i++) push(16'h3000 + 16'(i));
    repeat (3) @(negedge clk);
    chk("R5 both full", 32'(full), 32'b11);
    chk("R5 no swap", 32'(fill_sel), 32'd0);
    chk("R5 producer stalled", 32'(wr_ready), 32'd0);
    for (int i = 0; i < 64; i++) pop(16'h2000 + 16'(i), "R5 drain buffer 1");
    chk("R5 flag of drained buffer", 32'(full), 32'b01);
    chk("R5 swap waits one edge", 32'(fill_sel), 32'd0);
    @(negedge clk);
    chk("R5 swap after drain", 32'(fill_sel), 32'd1);
    for (int i = 0; i < 64; i++) pop(16'h3000 + 16'(i), "R5 drain buffer 0");
    chk("R5 all empty", 32'(full), 32'd0);
  endtask

  task automatic t_diag_rw();
    logic [15:0] rd; logic er; int n;
    cpu_acc(1'b1, 8'h8A, 2'b01, 16'hA5A5, rd, er, n);
    chk("R8 write latency lower bound", 32'(n >= 4), 32'd1);
    chk("R6 write err", 32'(er), 32'd0);
    cpu_acc(1'b1, 8'h0A, 2'b01, 16'h5A5A, rd, er, n);
    cpu_acc(1'b0, 8'h8A, 2'b01, 16'h0, rd, er, n);
    chk("R6 read buffer 1 entry 5", 32'(rd), 32'hA5A5);
    chk("R8 read latency lower bound", 32'(n >= 4), 32'd1);
    cpu_acc(1'b0, 8'h0A, 2'b01, 16'h0, rd, er, n);
    chk("R6 read buffer 0 entry 5", 32'(rd), 32'h5A5A);
    cpu_acc(1'b0, 8'h7E, 2'b01, 16'h0, rd, er, n);
    chk("R6 buffer 0 entry 63", 32'(rd), 32'h303F);
    cpu_acc(1'b0, 8'h80, 2'b01, 16'h0, rd, er, n);
    chk("R6 buffer 1 entry 0", 32'(rd), 32'h2000);
    chk("R9 diag does not disturb roles", 32'({full, fill_sel}), 32'b001);
  endtask

  task automatic t_illegal();
    logic [15:0] rd; logic er; int n;
    cpu_acc(1'b1, 8'h8C, 2'b00, 16'hFFFF, rd, er, n);
    chk("R7 byte err", 32'(er), 32'd1);
    chk("R7 err latency", 32'(n), 32'd1);
    cpu_acc(1'b1, 8'h8C, 2'b10, 16'hFFFF, rd, er, n);
    chk("R7 word err", 32'(er), 32'd1);
    cpu_acc(1'b1, 8'h8D, 2'b01, 16'hFFFF, rd, er, n);
    chk("R7 odd address err", 32'(er), 32'd1);
    cpu_acc(1'b0, 8'h8D, 2'b01, 16'h0, rd, er, n);
    chk("R7 illegal read data zero", 32'(rd), 32'd0);
    cpu_acc(1'b0, 8'h8C, 2'b01, 16'h0, rd, er, n);
    chk("R7 entry untouched", 32'(rd), 32'h2006);
    chk("R7 legal read no err", 32'(er), 32'd0);
  endtask

  task automatic t_drain_write();
    logic [15:0] rd; logic er; int n;
    for (int i = 0; i < 64; i++) push(16'h4000 + 16'(i));
    @(negedge clk);
    chk("R3 swap to drain buffer 1", 32'(fill_sel), 32'd0);
    cpu_acc(1'b1, 8'h92, 2'b01, 16'hBEEF, rd, er, n);
    @(negedge clk);
    chk("R9 full unchanged", 32'(full), 32'b10);
    chk("R9 fill_sel unchanged", 32'(fill_sel), 32'd0);
    chk("R9 rd_valid unchanged", 32'(rd_valid), 32'd1);
    for (int i = 0; i < 64; i++)
      pop((i == 9) ? 16'hBEEF : 16'h4000 + 16'(i), "R9 drain sees diag write");
    chk("R9 drained", 32'(full), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_fill_drain();
    t_both_full();
    t_diag_rw();
    t_illegal();
    t_drain_write();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule